// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a multi-cycle load/store processor. It holds a micro-address register and a small built-in control store. Each cycle the stored word at the current micro-address drives a set of packed control fields to the datapath: the ALU operation, the two ALU operand selects, the register-file action, the memory action and the PC-write source. One further field of the same word tells the sequencer where to go next. It can step to the following word, return to the first fetch word, or jump to an entry chosen by decoding the instruction opcode.

The control store covers the shared two-word fetch and decode prologue, a two-word register-to-register routine and a one-word branch-if-equal routine. The datapath supplies the instruction opcode, which is held stable by the instruction register, and the branch condition flag, which is the ALU zero result. The block produces a single PC write strobe that already accounts for the conditional case. All control outputs are combinational decodes of the current micro-address, so each output is a clean function of the sequencer state.

Top module: `ucode_seq`

## Requirements
- R1: While rst_n is low the micro-address is 0 and the outputs show the first fetch word. After release, the first cycle shows that word and the next cycle shows the second fetch word.
- R2: The first fetch word gives alu_ctl=0 (add), src1_sel=0 (PC), src2_sel=1 (constant 4), rf_ctl=0 (idle), mem_ctl=1 (read at PC), pc_src=1 (from ALU) and seq_ctl=0 (step).
- R3: The second fetch word gives alu_ctl=0 (add), src1_sel=0 (PC), src2_sel=3 (extended immediate shifted left by 2), rf_ctl=1 (read), mem_ctl=0 (idle), pc_src=0 (none) and seq_ctl=2 (dispatch).
- R4: At dispatch the opcode picks the next word. Opcode 0x00 enters the register routine, opcode 0x04 enters the branch word, and any other opcode returns to the first fetch word.
- R5: The register routine is two words. The first gives alu_ctl=2 (function code), src1_sel=1 (A), src2_sel=0 (B), seq_ctl=0, with rf_ctl, mem_ctl and pc_src all 0. The second gives rf_ctl=2 (write ALU result), seq_ctl=1 (to fetch), and every other field 0.
- R6: The branch word gives alu_ctl=1 (subtract), src1_sel=1 (A), src2_sel=0 (B), rf_ctl=0, mem_ctl=0, pc_src=2 (conditional) and seq_ctl=1 (to fetch).
- R7: A word with seq_ctl=0 is followed, one cycle later, by the word at the next micro-address. A word with seq_ctl=1 is followed by the first fetch word.
- R8: pc_we is 1 when pc_src is 1 (ALU) or 3 (jump), equals cond_flag when pc_src is 2, and is 0 when pc_src is 0.
- R9: The opcode is ignored in every cycle except a dispatch cycle. cond_flag affects nothing but pc_we in a conditional word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OP_W (6) | Opcode from the instruction register |
| cond_flag | input | 1 | Branch condition (ALU zero) |
| alu_ctl | output | 2 | ALU operation field |
| src1_sel | output | 1 | First operand select |
| src2_sel | output | 2 | Second operand select |
| rf_ctl | output | 2 | Register-file action |
| mem_ctl | output | 2 | Memory action |
| pc_src | output | 2 | PC-write source field |
| seq_ctl | output | 2 | Sequencing field of the current word |
| pc_we | output | 1 | Resolved PC write strobe |

## Verification
Every output is decoded from the micro-address register, so a wrong next address appears on the ports in the very next cycle as a wrong control word. A missed dispatch is one example: it shows a fetch word where a routine word was due. A step that fails to advance shows the same word twice in a row. The bench walks whole instructions cycle by cycle, comparing every field, so a fault is caught in the first cycle it changes the sequence. It also changes the opcode and the condition flag in cycles where they must have no effect, and it applies reset in the middle of a routine.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

   typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNC = 2'd2, ALU_RSV = 2'd3} alu_e;
   typedef enum logic       {S1_PC = 1'b0, S1_A = 1'b1} src1_e;
   typedef enum logic [1:0] {S2_B = 2'd0, S2_FOUR = 2'd1, S2_IMM = 2'd2, S2_IMMSH = 2'd3} src2_e;
   typedef enum logic [1:0] {RF_IDLE = 2'd0, RF_READ = 2'd1, RF_WR_ALU = 2'd2, RF_WR_MDR = 2'd3} rf_e;
   typedef enum logic [1:0] {MM_IDLE = 2'd0, MM_RD_PC = 2'd1, MM_RD_ALU = 2'd2, MM_WR_ALU = 2'd3} mem_e;
   typedef enum logic [1:0] {PW_NONE = 2'd0, PW_ALU = 2'd1, PW_COND = 2'd2, PW_JUMP = 2'd3} pcw_e;
   typedef enum logic [1:0] {SQ_STEP = 2'd0, SQ_FETCH = 2'd1, SQ_DISP = 2'd2, SQ_RSV = 2'd3} seq_e;

   typedef struct packed {
      alu_e  alu;
      src1_e s1;
      src2_e s2;
      rf_e   rf;
      mem_e  mm;
      pcw_e  pw;
      seq_e  sq;
   } uword_t;

   localparam int unsigned UWORD_W = $bits(uword_t);

   // control store layout
   localparam int unsigned UA_FETCH0 = 0;
   localparam int unsigned UA_FETCH1 = 1;
   localparam int unsigned UA_RT0    = 2;
   localparam int unsigned UA_RT1    = 3;
   localparam int unsigned UA_BEQ    = 4;
   localparam int unsigned UA_USED   = 5;

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
   import ucode_pkg::*;
#(
   parameter int unsigned UA_W = 3
) (
   input  logic [UA_W-1:0] addr,
   output uword_t          word
);

   localparam int unsigned DEPTH = 1 << UA_W;

   if (DEPTH < UA_USED) begin : g_depth_chk
      $error("ucode_rom: UA_W too small for the control store");
   end

   function automatic uword_t word_at(int unsigned a);
      uword_t w;
      w = '{alu: ALU_ADD, s1: S1_PC, s2: S2_B, rf: RF_IDLE, mm: MM_IDLE, pw: PW_NONE, sq: SQ_FETCH};
      case (a)
         UA_FETCH0: w = '{alu: ALU_ADD, s1: S1_PC, s2: S2_FOUR, rf: RF_IDLE,
                          mm: MM_RD_PC, pw: PW_ALU, sq: SQ_STEP};
         UA_FETCH1: w = '{alu: ALU_ADD, s1: S1_PC, s2: S2_IMMSH, rf: RF_READ,
                          mm: MM_IDLE, pw: PW_NONE, sq: SQ_DISP};
         UA_RT0:    w = '{alu: ALU_FUNC, s1: S1_A, s2: S2_B, rf: RF_IDLE,
                          mm: MM_IDLE, pw: PW_NONE, sq: SQ_STEP};
         UA_RT1:    w = '{alu: ALU_ADD, s1: S1_PC, s2: S2_B, rf: RF_WR_ALU,
                          mm: MM_IDLE, pw: PW_NONE, sq: SQ_FETCH};
         UA_BEQ:    w = '{alu: ALU_SUB, s1: S1_A, s2: S2_B, rf: RF_IDLE,
                          mm: MM_IDLE, pw: PW_COND, sq: SQ_FETCH};
         default:   ;
      endcase
      return w;
   endfunction

   uword_t store [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      assign store[i] = word_at(i);
   end

   assign word = store[addr];

endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch #(
   parameter int unsigned OP_W      = 6,
   parameter int unsigned UA_W      = 3,
   parameter int unsigned OP_RTYPE  = 0,
   parameter int unsigned OP_BEQ    = 4,
   parameter int unsigned ENT_RTYPE = 2,
   parameter int unsigned ENT_BEQ   = 4,
   parameter int unsigned ENT_FETCH = 0
) (
   input  logic [OP_W-1:0] opcode,
   output logic [UA_W-1:0] target
);

   localparam logic [OP_W-1:0] OPC_R = OP_W'(OP_RTYPE);
   localparam logic [OP_W-1:0] OPC_B = OP_W'(OP_BEQ);

   if (OP_RTYPE == OP_BEQ) begin : g_op_chk
      $error("ucode_dispatch: class opcodes must differ");
   end
   if (OP_RTYPE >= (1 << OP_W) || OP_BEQ >= (1 << OP_W)) begin : g_opw_chk
      $error("ucode_dispatch: opcode does not fit OP_W");
   end

   always_comb begin
      if (opcode == OPC_R)      target = UA_W'(ENT_RTYPE);
      else if (opcode == OPC_B) target = UA_W'(ENT_BEQ);
      else                      target = UA_W'(ENT_FETCH);
   end

endmodule

// File: rtl/ucode_next_addr.sv
module ucode_next_addr
   import ucode_pkg::*;
#(
   parameter int unsigned UA_W       = 3,
   parameter int unsigned FETCH_ADDR = 0,
   parameter bit          ASYNC_RST  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  seq_e            seq,
   input  logic [UA_W-1:0] disp_target,
   output logic [UA_W-1:0] upc
);

   localparam logic [UA_W-1:0] FETCH_UA = UA_W'(FETCH_ADDR);

   logic [UA_W-1:0] upc_nxt;

   always_comb begin
      case (seq)
         SQ_STEP: upc_nxt = upc + UA_W'(1);
         SQ_DISP: upc_nxt = disp_target;
         default: upc_nxt = FETCH_UA;
      endcase
   end

   if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) upc <= FETCH_UA;
         else        upc <= upc_nxt;
      end
   end else begin : g_srst
      always_ff @(posedge clk) begin
         if (!rst_n) upc <= FETCH_UA;
         else        upc <= upc_nxt;
      end
   end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
   import ucode_pkg::*;
#(
   parameter int unsigned OP_W      = 6,
   parameter int unsigned UA_W      = 3,
   parameter int unsigned OP_RTYPE  = 0,
   parameter int unsigned OP_BEQ    = 4,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] opcode,
   input  logic            cond_flag,
   output logic [1:0]      alu_ctl,
   output logic            src1_sel,
   output logic [1:0]      src2_sel,
   output logic [1:0]      rf_ctl,
   output logic [1:0]      mem_ctl,
   output logic [1:0]      pc_src,
   output logic [1:0]      seq_ctl,
   output logic            pc_we
);

   if (UWORD_W < 13) begin : g_w_chk
      $error("ucode_seq: microword narrower than required");
   end

   logic [UA_W-1:0] upc;
   logic [UA_W-1:0] disp_target;
   uword_t          uw;

   ucode_rom #(.UA_W(UA_W)) u_rom (
      .addr (upc),
      .word (uw)
   );

   ucode_dispatch #(
      .OP_W      (OP_W),
      .UA_W      (UA_W),
      .OP_RTYPE  (OP_RTYPE),
      .OP_BEQ    (OP_BEQ),
      .ENT_RTYPE (UA_RT0),
      .ENT_BEQ   (UA_BEQ),
      .ENT_FETCH (UA_FETCH0)
   ) u_disp (
      .opcode (opcode),
      .target (disp_target)
   );

   ucode_next_addr #(
      .UA_W       (UA_W),
      .FETCH_ADDR (UA_FETCH0),
      .ASYNC_RST  (ASYNC_RST)
   ) u_next (
      .clk         (clk),
      .rst_n       (rst_n),
      .seq         (uw.sq),
      .disp_target (disp_target),
      .upc         (upc)
   );

   always_comb begin
      case (uw.pw)
         PW_ALU, PW_JUMP: pc_we = 1'b1;
         PW_COND:         pc_we = cond_flag;
         default:         pc_we = 1'b0;
      endcase
   end

   assign alu_ctl  = uw.alu;
   assign src1_sel = uw.s1;
   assign src2_sel = uw.s2;
   assign rf_ctl   = uw.rf;
   assign mem_ctl  = uw.mm;
   assign pc_src   = uw.pw;
   assign seq_ctl  = uw.sq;

endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk #(
   parameter int unsigned UA_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cond_flag,
   input logic [UA_W-1:0] upc,
   input logic [1:0]      alu_ctl,
   input logic [1:0]      pc_src,
   input logic [1:0]      seq_ctl,
   input logic            pc_we
);

   a_r1_reset_fetch: assert property (@(posedge clk)
      !rst_n |=> upc == '0);

   a_r7_step_adv: assert property (@(posedge clk) disable iff (!rst_n)
      seq_ctl == 2'd0 |=> upc == $past(upc) + UA_W'(1));

   a_r7_fetch_ret: assert property (@(posedge clk) disable iff (!rst_n)
      seq_ctl == 2'd1 |=> upc == '0);

   a_r4_disp_target: assert property (@(posedge clk) disable iff (!rst_n)
      seq_ctl == 2'd2 |=> (upc == UA_W'(0) || upc == UA_W'(2) || upc == UA_W'(4)));

   a_r6_branch_word: assert property (@(posedge clk) disable iff (!rst_n)
      upc == UA_W'(4) |-> (alu_ctl == 2'd1 && pc_src == 2'd2 && seq_ctl == 2'd1));

   a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_src == 2'd0 || (pc_src == 2'd2 && !cond_flag)) |-> !pc_we);

   a_r8_cond_write: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_src == 2'd2 && cond_flag) |-> pc_we);

endmodule

bind ucode_seq ucode_seq_chk #(.UA_W(UA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cond_flag (cond_flag),
   .upc       (upc),
   .alu_ctl   (alu_ctl),
   .pc_src    (pc_src),
   .seq_ctl   (seq_ctl),
   .pc_we     (pc_we)
);

// File: tb/sim_ucode_seq.sv
module sim_ucode_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = 6'd0;
   logic       cond_flag = 1'b0;
   logic [1:0] alu_ctl, src2_sel, rf_ctl, mem_ctl, pc_src, seq_ctl;
   logic       src1_sel, pc_we;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   ucode_seq u0 (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .cond_flag(cond_flag),
      .alu_ctl(alu_ctl), .src1_sel(src1_sel), .src2_sel(src2_sel),
      .rf_ctl(rf_ctl), .mem_ctl(mem_ctl), .pc_src(pc_src),
      .seq_ctl(seq_ctl), .pc_we(pc_we)
   );

   // expected words {alu, src1, src2, rf, mem, pc_src, seq}
   localparam logic [12:0] W_F0 = {2'd0, 1'd0, 2'd1, 2'd0, 2'd1, 2'd1, 2'd0}; // R2
   localparam logic [12:0] W_F1 = {2'd0, 1'd0, 2'd3, 2'd1, 2'd0, 2'd0, 2'd2}; // R3
   localparam logic [12:0] W_R0 = {2'd2, 1'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0}; // R5
   localparam logic [12:0] W_R1 = {2'd0, 1'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd1}; // R5
   localparam logic [12:0] W_BQ = {2'd1, 1'd1, 2'd0, 2'd0, 2'd0, 2'd2, 2'd1}; // R6

   localparam logic [5:0] OP_R = 6'h00, OP_B = 6'h04, OP_X = 6'h23, OP_Y = 6'h3F;

   // row: {opcode, cond_flag, expected word, expected pc_we}
   localparam int NV = 19;
   localparam logic [20:0] VEC [NV] = '{
      {OP_R, 1'b0, W_F0, 1'b1},  // R2 R8
      {OP_R, 1'b1, W_F1, 1'b0},  // R3 R9 cond ignored
      {OP_X, 1'b1, W_R0, 1'b0},  // R4 R5 R9 opcode change ignored
      {OP_X, 1'b0, W_R1, 1'b0},  // R5 R7
      {OP_B, 1'b0, W_F0, 1'b1},  // R7 return
      {OP_B, 1'b0, W_F1, 1'b0},
      {OP_B, 1'b1, W_BQ, 1'b1},  // R4 R6 R8 taken
      {OP_X, 1'b0, W_F0, 1'b1},
      {OP_B, 1'b0, W_F1, 1'b0},
      {OP_R, 1'b0, W_BQ, 1'b0},  // R8 not taken, R9
      {OP_X, 1'b1, W_F0, 1'b1},
      {OP_X, 1'b0, W_F1, 1'b0},
      {OP_R, 1'b0, W_F0, 1'b1},  // R4 other opcode back to fetch
      {OP_Y, 1'b0, W_F1, 1'b0},
      {OP_R, 1'b0, W_F0, 1'b1},  // R4
      {OP_R, 1'b0, W_F1, 1'b0},
      {OP_R, 1'b1, W_R0, 1'b0},  // R9 cond ignored
      {OP_R, 1'b0, W_R1, 1'b0},
      {OP_R, 1'b0, W_F0, 1'b1}
   };

   function automatic logic [13:0] observed();
      return {alu_ctl, src1_sel, src2_sel, rf_ctl, mem_ctl, pc_src, seq_ctl, pc_we};
   endfunction

   task automatic check(input logic [13:0] exp, input string req);
      n_chk++;
      if (observed() !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, observed(), exp, $time);
      end
   endtask

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check({W_F0, 1'b1}, "R1 reset state");
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         if (i != 0) @(negedge clk);
         opcode    = VEC[i][20:15];
         cond_flag = VEC[i][14];
         #1;
         check(VEC[i][13:0], $sformatf("R4/R7 vector %0d", i));
      end
      // reset in the middle of the register routine
      @(negedge clk); opcode = OP_R; cond_flag = 1'b0; #1;
      check({W_F1, 1'b0}, "R3 before mid reset");
      @(negedge clk); #1;
      check({W_R0, 1'b0}, "R5 before mid reset");
      rst_n = 1'b0; #1;
      check({W_F0, 1'b1}, "R1 mid-routine reset");
      repeat (2) @(negedge clk);
      #1;
      check({W_F0, 1'b1}, "R1 held in reset");
      rst_n = 1'b1;
      @(negedge clk); #1;
      check({W_F1, 1'b0}, "R1 release then second fetch word");
      @(negedge clk); opcode = OP_Y; #1;
      check({W_R0, 1'b0}, "R9 dispatched before opcode change");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule